// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block sits between an external maskable interrupt line and a processor core's bus controller. The interrupt request is an asynchronous, active-high, level-sensitive input. It passes through a synchroniser before the block acts on it, and it is acted on only while an interrupt-enable flag is set. When a request is recognised, the block asks the bus controller for two acknowledge bus cycles in a row. It holds a bus lock across both cycles, so that no other bus cycle can slip between them.

The link to the bus controller is a plain request/done pair. `cyc_req` stays high for as long as an acknowledge cycle is wanted. A one-clock `cyc_done` pulse ends the current cycle and returns that cycle's data byte. The byte from the first cycle is dropped. The byte from the second cycle is captured as the interrupt vector and offered to the core on a valid/ready stream. Back-pressure rules: once `vec_valid` rises it stays high, and `vec_data` stays unchanged, until `vec_ready` is sampled high at a rising edge. The core may hold `vec_ready` low for as long as it likes, and no new sequence starts during that time. The handshake edge clears the enable flag, so the core has to set it again before the next interrupt is taken.

The requester must keep the line high until both acknowledge cycles have been performed. A request that falls before the block recognises it is not serviced. Once the first acknowledge cycle has started, the sequence runs to completion even if the line falls.

Top module: `irq_ack_seq`

## Requirements
- R1: While reset is held and right after it, `cyc_req`, `bus_lock`, `cyc_first`, `vec_valid` and `ie_flag` are all 0.
- R2: `irq_async` passes through SYNC_STAGES flip-flops (default 2). With `ie_flag` already 1 and the block idle, if `irq_async` is high at rising edge k, then `cyc_req` becomes 1 just after edge k+SYNC_STAGES (edge k+2 by default).
- R3: While `ie_flag` is 0, a high request starts no sequence. A request that is removed before `ie_flag` is set is never serviced, even once the flag is set.
- R4: A sequence is two acknowledge cycles. `cyc_req` stays 1 continuously from the start of the first cycle until the second one ends. `cyc_first` is 1 during the first cycle and 0 during the second. A cycle ends at the rising edge where `cyc_done` is sampled 1 while `cyc_req` is 1.
- R5: `bus_lock` is 1 in every clock in which `cyc_req` is 1 and in no other clock. It falls at the edge that ends the second cycle.
- R6: `cyc_rdata` at the end of the first cycle is discarded. `cyc_rdata` at the end of the second cycle is captured into `vec_data`, and `vec_valid` becomes 1 at that same edge.
- R7: While `vec_valid` is 1 and `vec_ready` is 0, `vec_valid` stays 1, `vec_data` is unchanged, and `cyc_req` stays 0.
- R8: The edge at which `vec_valid` and `vec_ready` are both 1 clears `vec_valid` and `ie_flag`. A request that is still held high then starts nothing until `ie_set` is pulsed. After the pulse, `cyc_req` rises one edge after the flag is set.
- R9: A pulse on `ie_set` sets `ie_flag` at the next edge, and a pulse on `ie_clr` clears it. If both are high at the same edge, `ie_set` wins.
- R10: Once the first acknowledge cycle has started, dropping `irq_async` does not abort the sequence. Both cycles complete and the vector is delivered.
- R11: `cyc_done` while `cyc_req` is 0 is ignored: no capture and no change to `vec_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_async | input | 1 | Asynchronous active-high interrupt request level |
| ie_set | input | 1 | Pulse: set the interrupt-enable flag |
| ie_clr | input | 1 | Pulse: clear the interrupt-enable flag |
| ie_flag | output | 1 | Current interrupt-enable flag |
| cyc_req | output | 1 | Acknowledge bus cycle wanted; held until `cyc_done` |
| cyc_first | output | 1 | 1 during the first acknowledge cycle, 0 during the second |
| bus_lock | output | 1 | Bus lock held across both acknowledge cycles |
| cyc_done | input | 1 | Pulse: current acknowledge cycle complete, `cyc_rdata` valid |
| cyc_rdata | input | VEC_W | Data byte returned by the acknowledge cycle |
| vec_valid | output | 1 | Captured vector available |
| vec_ready | input | 1 | Core accepts the vector |
| vec_data | output | VEC_W | Captured interrupt vector |

## Verification
Most internal faults show at the ports within one clock:
- A sequencer state that is wrong shows as `bus_lock` without `cyc_req`, as the phase flag reversed at the start of a sequence, or as a cycle request while a vector is still waiting.
- A lost or extra synchroniser stage moves the rise of `cyc_req` by one edge away from the position the bench counts.
- Capturing the wrong byte shows up on `vec_data` at the edge that ends the second cycle.

A flag that is not cleared on delivery stays hidden until the request is held high past the handshake. It then surfaces as an unwanted third acknowledge cycle within two clocks.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CYC1    = 2'd1,
    ST_CYC2    = 2'd2,
    ST_DELIVER = 2'd3
  } ack_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[LAST];
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_ack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic irq_seen,
  input  logic ie_set,
  input  logic ie_clr,
  input  logic cyc_done,
  input  logic vec_ready,
  output logic ie_flag,
  output logic cyc_req,
  output logic cyc_first,
  output logic bus_lock,
  output logic capture,
  output logic vec_valid
);
  ack_state_t state, state_nx;
  logic       deliver;

  assign deliver = (state == ST_DELIVER) && vec_ready;
  assign capture = (state == ST_CYC2) && cyc_done;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (irq_seen && ie_flag) state_nx = ST_CYC1;
      ST_CYC1:    if (cyc_done)            state_nx = ST_CYC2;
      ST_CYC2:    if (cyc_done)            state_nx = ST_DELIVER;
      ST_DELIVER: if (vec_ready)           state_nx = ST_IDLE;
      default:                             state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   ie_flag <= 1'b0;
    else if (ie_set)              ie_flag <= 1'b1;
    else if (ie_clr || deliver)   ie_flag <= 1'b0;
  end

  assign cyc_req   = (state == ST_CYC1) || (state == ST_CYC2);
  assign bus_lock  = cyc_req;
  assign cyc_first = (state == ST_CYC1);
  assign vec_valid = (state == ST_DELIVER);
endmodule

// File: rtl/vec_hold.sv
module vec_hold #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [VEC_W-1:0] din,
  output logic [VEC_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n)       dout <= '0;
    else if (capture) dout <= din;
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_async,
  input  logic             ie_set,
  input  logic             ie_clr,
  output logic             ie_flag,
  output logic             cyc_req,
  output logic             cyc_first,
  output logic             bus_lock,
  input  logic             cyc_done,
  input  logic [VEC_W-1:0] cyc_rdata,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic [VEC_W-1:0] vec_data
);
  logic irq_seen;
  logic capture;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(irq_async), .q_sync(irq_seen)
  );

  irq_ack_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .irq_seen(irq_seen),
    .ie_set(ie_set), .ie_clr(ie_clr), .cyc_done(cyc_done),
    .vec_ready(vec_ready), .ie_flag(ie_flag), .cyc_req(cyc_req),
    .cyc_first(cyc_first), .bus_lock(bus_lock), .capture(capture),
    .vec_valid(vec_valid)
  );

  vec_hold #(.VEC_W(VEC_W)) u_vec (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .din(cyc_rdata), .dout(vec_data)
  );
endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ie_set,
  input logic             ie_flag,
  input logic             cyc_req,
  input logic             cyc_first,
  input logic             bus_lock,
  input logic             cyc_done,
  input logic             vec_valid,
  input logic             vec_ready,
  input logic [VEC_W-1:0] vec_data
);
  a_r5_lock_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req |-> bus_lock);

  a_r5_lock_ends_in_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> vec_valid);

  a_r4_starts_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_req) |-> cyc_first);

  a_r4_phase_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cyc_first) && cyc_req) |-> $past(cyc_done));

  a_r3_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_req) |-> $past(ie_flag));

  a_r7_hold_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data)));

  a_r7_no_req_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !cyc_req);

  a_r8_clear_on_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready && !ie_set) |=> !ie_flag);
endmodule

bind irq_ack_seq irq_ack_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ie_set(ie_set), .ie_flag(ie_flag),
  .cyc_req(cyc_req), .cyc_first(cyc_first), .bus_lock(bus_lock),
  .cyc_done(cyc_done), .vec_valid(vec_valid), .vec_ready(vec_ready),
  .vec_data(vec_data)
);

// File: tb/tb_irq_ack_seq.sv
`timescale 1ns/1ps
module tb_irq_ack_seq;
  logic       clk = 1'b0;
  logic       rst_n, irq_async, ie_set, ie_clr, cyc_done, vec_ready;
  logic [7:0] cyc_rdata;
  logic       ie_flag, cyc_req, cyc_first, bus_lock, vec_valid;
  logic [7:0] vec_data;
  int checks = 0;
  int errors = 0;
  bit done_all = 1'b0;

  always #4 clk = ~clk;

  irq_ack_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_async(irq_async), .ie_set(ie_set),
    .ie_clr(ie_clr), .ie_flag(ie_flag), .cyc_req(cyc_req),
    .cyc_first(cyc_first), .bus_lock(bus_lock), .cyc_done(cyc_done),
    .cyc_rdata(cyc_rdata), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_data(vec_data)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_set();
    ie_set = 1'b1; tick(); ie_set = 1'b0;
  endtask

  task automatic bus_done(input logic [7:0] d);
    cyc_done = 1'b1; cyc_rdata = d; tick(); cyc_done = 1'b0; cyc_rdata = 8'h00;
  endtask

  task automatic accept();
    vec_ready = 1'b1; tick(); vec_ready = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; irq_async = 0; ie_set = 0; ie_clr = 0;
    cyc_done = 0; vec_ready = 0; cyc_rdata = 8'h00;
    repeat (3) tick();
    chk("R1 cyc_req in reset", cyc_req, 0);
    rst_n = 1'b1; tick();
    chk("R1 outputs after reset", {cyc_req, bus_lock, cyc_first, vec_valid, ie_flag}, 0);
  endtask

  task automatic t_enable_flag();
    pulse_set();
    chk("R9 ie_set sets flag", ie_flag, 1);
    ie_clr = 1'b1; tick(); ie_clr = 1'b0;
    chk("R9 ie_clr clears flag", ie_flag, 0);
    ie_set = 1'b1; ie_clr = 1'b1; tick(); ie_set = 1'b0; ie_clr = 1'b0;
    chk("R9 set wins over clear", ie_flag, 1);
    ie_clr = 1'b1; tick(); ie_clr = 1'b0;
  endtask

  task automatic t_masked_and_dropped();
    int seen = 0;
    irq_async = 1'b1;
    for (int i = 0; i < 8; i++) begin tick(); seen += cyc_req; end
    chk("R3 masked request starts nothing", seen, 0);
    irq_async = 1'b0;
    repeat (4) tick();
    pulse_set();
    seen = 0;
    for (int i = 0; i < 8; i++) begin tick(); seen += cyc_req; end
    chk("R3 dropped request not serviced", seen, 0);
    ie_clr = 1'b1; tick(); ie_clr = 1'b0;
  endtask

  task automatic t_stray_done();
    bus_done(8'h77);
    chk("R11 stray done ignored", {vec_valid, cyc_req}, 0);
  endtask

  task automatic t_timing();
    int lock_bad = 0;
    pulse_set();
    irq_async = 1'b1;
    tick(); chk("R2 no request after 1 edge", cyc_req, 0);
    tick(); chk("R2 no request after 2 edges", cyc_req, 0);
    tick(); chk("R2 request after 3 edges", cyc_req, 1);
    chk("R5 lock with first cycle", bus_lock, 1);
    chk("R4 first phase flagged", cyc_first, 1);
    repeat (2) begin tick(); lock_bad += (cyc_req != 1) + (bus_lock != 1) + (cyc_first != 1); end
    chk("R4 first cycle held", lock_bad, 0);
    bus_done(8'hAA);
    chk("R4 second cycle follows", {cyc_req, cyc_first, bus_lock, vec_valid}, 4'b1010);
    repeat (3) begin tick(); lock_bad += (cyc_req != 1) + (bus_lock != 1) + (cyc_first != 0); end
    chk("R5 lock held through second cycle", lock_bad, 0);
    bus_done(8'h5C);
    chk("R5 lock released at second done", {cyc_req, bus_lock}, 0);
    chk("R6 second byte captured", {vec_valid, vec_data}, {1'b1, 8'h5C});
    chk("R8 flag held until delivery", ie_flag, 1);
    irq_async = 1'b0;
    accept();
    chk("R8 delivery clears valid and flag", {vec_valid, ie_flag}, 0);
  endtask

  task automatic t_backpressure_level();
    int bad = 0;
    pulse_set();
    irq_async = 1'b1;
    repeat (3) tick();
    chk("R2 second sequence started", cyc_req, 1);
    bus_done(8'h11);
    bus_done(8'hC3);
    for (int i = 0; i < 5; i++) begin
      tick(); bad += (vec_valid != 1) + (vec_data != 8'hC3) + cyc_req;
    end
    chk("R7 vector held under back-pressure", bad, 0);
    accept();
    bad = 0;
    for (int i = 0; i < 8; i++) begin tick(); bad += cyc_req; end
    chk("R8 held request waits for enable", {ie_flag, 4'(bad)}, 0);
    pulse_set();
    tick();
    chk("R8 re-enable restarts sequence", cyc_req, 1);
    bus_done(8'h22);
    bus_done(8'h9E);
    irq_async = 1'b0;
    chk("R6 latest second byte", vec_data, 8'h9E);
    accept();
  endtask

  task automatic t_drop_midway();
    pulse_set();
    irq_async = 1'b1;
    repeat (3) tick();
    irq_async = 1'b0;
    repeat (4) tick();
    chk("R10 sequence continues after drop", cyc_req, 1);
    bus_done(8'h01);
    bus_done(8'h4D);
    chk("R10 vector delivered after drop", {vec_valid, vec_data}, {1'b1, 8'h4D});
    accept();
  endtask

  initial begin
    t_reset();
    t_enable_flag();
    t_masked_and_dropped();
    t_stray_done();
    t_timing();
    t_backpressure_level();
    t_drop_midway();
    done_all = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_all) begin
      checks++; errors++;
      $display("FAIL R4 watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule